// File: doc/BRIEF.md
# Voltage-Code Reference Slew Controller

This block turns a voltage-identification (VID) code into the reference code that drives a regulator's reference DAC. The code is sampled on every switching-cycle strobe. When the sampled value moves away from the code currently in force, the block qualifies it: one strobe notices the difference, and two further strobes must show the same new value before it becomes the target. The reference then walks toward the target one LSB (one 25 mV step) every two strobes, in either direction, and stops on the target without passing it.

Clock edges without a strobe change nothing. The VID code maps to a reference code through a linear map, `REF_OFFSET + REF_SCALE * code`. Reset loads the reference straight from the code present at reset, with no slew. A code that comes back to the code in force before qualification ends is dropped. A fresh code that shows up while the reference is still slewing goes through the same qualification. During that time the reference keeps moving toward the old target, and it turns only once the new code is accepted.

The controller has three states. IDLE: settled, and the reference equals the target. QUAL: a candidate code is being confirmed. SLEW: the reference is moving toward an accepted target. Transitions happen only on strobes:
- IDLE→QUAL or SLEW→QUAL on detection (sampled code differs from the code in force).
- QUAL→QUAL with the count restarted when the candidate changes to yet another code.
- QUAL→SLEW on acceptance, or on abandonment while the reference is still away from the target.
- QUAL→IDLE on abandonment with the reference already on target.
- SLEW→IDLE on the strobe after the reference reaches the target.

Top module: `vid_ref_stepper`

## Requirements
- R1: While reset is asserted, the reference loads `REF_OFFSET + REF_SCALE * vid_code` directly, and after reset `busy` is 0.
- R2: On clock edges where `cyc_stb` is 0, neither `ref_code` nor `busy` changes.
- R3: A code applied before strobe 1 and held is registered at strobe 1 and detected at strobe 2. `busy` is 1 after strobe 2.
- R4: The new code is accepted at strobe 4, after being sampled unchanged at strobes 2 and 3. `ref_code` does not move before strobe 6.
- R5: A code that falls back to the code in force before acceptance (held for one or two strobes) never moves `ref_code`. `busy` returns to 0 one strobe after the code is seen back.
- R6: After acceptance at strobe 4, step m of the reference lands at strobe 4+2m. Each step changes `ref_code` by exactly one LSB.
- R7: Slewing works upward and downward and ends exactly on the target, with no overshoot.
- R8: `busy` goes to 0 on the strobe after the reference reaches the target. Whenever `busy` is 0, `ref_code` equals the mapped code in force.
- R9: A new code that appears while slewing is qualified the same way. Until it is accepted, steps toward the old target continue on their two-strobe rhythm. From the accepting strobe a, steps toward the new target land at strobes a+2m.
- R10: The VID-to-reference map is `REF_OFFSET + REF_SCALE * code`, so it holds at the lowest and highest code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe marking a switching cycle |
| vid_code | input | VID_W | Requested voltage-identification code |
| ref_code | output | REF_W | Current reference code, one LSB per 25 mV |
| busy | output | 1 | High from detection until settled on target |

## Verification
The bench builds the block with a 5-bit code, an 8-bit reference, an offset of 16 and a scale of 2. With a scale of 2, even a single code step needs several reference steps. This makes a redirect in mid-slew easy to stage, and it keeps the old and new directions apart in the reference sequence. Offset 16 together with the top code (reference 78) exercises both ends of the map inside the 8-bit range. The confirm count and step divider stay at their defaults of two strobes, so the strobe numbers in R3 to R9 apply as written.

// File: rtl/vidstep_pkg.sv
package vidstep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_SLEW = 2'd2
    } qual_state_t;

    localparam int DEF_CONFIRM_N = 2;
    localparam int DEF_STEP_DIV  = 2;

endpackage

// File: rtl/vid_map.sv
module vid_map #(
    parameter int VID_W      = 6,
    parameter int REF_W      = 8,
    parameter int REF_OFFSET = 8,
    parameter int REF_SCALE  = 1
) (
    input  logic [VID_W-1:0] vid_i,
    output logic [REF_W-1:0] ref_o
);

    localparam int MAX_CODE = (1 << VID_W) - 1;
    localparam int MAX_REF  = REF_OFFSET + REF_SCALE * MAX_CODE;

    logic [31:0] wide;

    always_comb begin
        wide  = 32'(REF_OFFSET) + 32'(REF_SCALE) * 32'(vid_i);
        ref_o = wide[REF_W-1:0];
    end

    // R10
    initial begin
        map_range_chk: assert (MAX_REF < (1 << REF_W));
    end

endmodule

// File: rtl/vid_qual_fsm.sv
module vid_qual_fsm
    import vidstep_pkg::*;
#(
    parameter int VID_W     = 6,
    parameter int CONFIRM_N = DEF_CONFIRM_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             at_target_i,
    output logic [VID_W-1:0] tgt_code_o,
    output logic             accept_o,
    output logic             busy_o
);

    localparam int CW = $clog2(CONFIRM_N + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(CONFIRM_N - 1);

    qual_state_t      state_q, state_d;
    logic [VID_W-1:0] samp_q;
    logic [VID_W-1:0] cand_q, cand_d;
    logic [VID_W-1:0] tgt_q, tgt_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            samp_q  <= vid_i;
            cand_q  <= vid_i;
            tgt_q   <= vid_i;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
            if (stb_i) begin
                samp_q <= vid_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        tgt_d   = tgt_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        if (stb_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (samp_q != tgt_q) begin
                        state_d = ST_QUAL;
                        cand_d  = samp_q;
                        cnt_d   = '0;
                    end
                end
                ST_SLEW: begin
                    if (samp_q != tgt_q) begin
                        state_d = ST_QUAL;
                        cand_d  = samp_q;
                        cnt_d   = '0;
                    end else if (at_target_i) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_QUAL: begin
                    if (samp_q == cand_q) begin
                        if (cnt_q == CNT_LAST) begin
                            tgt_d   = cand_q;
                            accept  = 1'b1;
                            state_d = ST_SLEW;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else if (samp_q == tgt_q) begin
                        state_d = at_target_i ? ST_IDLE : ST_SLEW;
                    end else begin
                        cand_d = samp_q;
                        cnt_d  = '0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tgt_code_o = tgt_q;
        accept_o   = accept;
        busy_o     = (state_q != ST_IDLE);
    end

    // R3
    detect_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && state_q == ST_IDLE && samp_q != tgt_q) |=> busy_o);

    // R4
    accept_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q != $past(tgt_q)) |-> ($past(samp_q) == tgt_q && $past(busy_o)));

    // R2
    fsm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(state_q) && $stable(tgt_q)));

endmodule

// File: rtl/ref_slewer.sv
module ref_slewer
    import vidstep_pkg::*;
#(
    parameter int REF_W    = 8,
    parameter int STEP_DIV = DEF_STEP_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             accept_i,
    input  logic [REF_W-1:0] tgt_ref_i,
    input  logic [REF_W-1:0] init_ref_i,
    output logic [REF_W-1:0] ref_o,
    output logic             at_target_o
);

    localparam int DW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(STEP_DIV - 1);

    logic [REF_W-1:0] ref_q;
    logic [DW-1:0]    div_q;
    logic             going_up;

    always_comb begin
        going_up    = (tgt_ref_i > ref_q);
        at_target_o = (ref_q == tgt_ref_i);
        ref_o       = ref_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= init_ref_i;
            div_q <= '0;
        end else if (stb_i) begin
            if (accept_i) begin
                div_q <= '0;
            end else if (!at_target_o) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    ref_q <= going_up ? ref_q + 1'b1 : ref_q - 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end else begin
                div_q <= '0;
            end
        end
    end

    // R6
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != $past(ref_q)) |->
            (ref_q == $past(ref_q) + REF_W'(1) || ref_q == $past(ref_q) - REF_W'(1)));

    // R6
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q != $past(ref_q)) |=> $stable(ref_q));

    // R2
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(ref_q));

    // R7
    up_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q > $past(ref_q)) |-> ($past(ref_q) < $past(tgt_ref_i)));

    // R7
    down_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q < $past(ref_q)) |-> ($past(ref_q) > $past(tgt_ref_i)));

endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
    import vidstep_pkg::*;
#(
    parameter int VID_W      = 6,
    parameter int REF_W      = 8,
    parameter int REF_OFFSET = 8,
    parameter int REF_SCALE  = 1,
    parameter int CONFIRM_N  = DEF_CONFIRM_N,
    parameter int STEP_DIV   = DEF_STEP_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  logic [VID_W-1:0] vid_code,
    output logic [REF_W-1:0] ref_code,
    output logic             busy
);

    logic [VID_W-1:0] tgt_code;
    logic [REF_W-1:0] tgt_ref;
    logic [REF_W-1:0] init_ref;
    logic             accept;
    logic             at_target;

    vid_map #(
        .VID_W(VID_W), .REF_W(REF_W),
        .REF_OFFSET(REF_OFFSET), .REF_SCALE(REF_SCALE)
    ) u_map_tgt (
        .vid_i(tgt_code),
        .ref_o(tgt_ref)
    );

    vid_map #(
        .VID_W(VID_W), .REF_W(REF_W),
        .REF_OFFSET(REF_OFFSET), .REF_SCALE(REF_SCALE)
    ) u_map_init (
        .vid_i(vid_code),
        .ref_o(init_ref)
    );

    vid_qual_fsm #(
        .VID_W(VID_W), .CONFIRM_N(CONFIRM_N)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (cyc_stb),
        .vid_i      (vid_code),
        .at_target_i(at_target),
        .tgt_code_o (tgt_code),
        .accept_o   (accept),
        .busy_o     (busy)
    );

    ref_slewer #(
        .REF_W(REF_W), .STEP_DIV(STEP_DIV)
    ) u_slew (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (cyc_stb),
        .accept_i   (accept),
        .tgt_ref_i  (tgt_ref),
        .init_ref_i (init_ref),
        .ref_o      (ref_code),
        .at_target_o(at_target)
    );

    // R8
    settled_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ref_code == tgt_ref));

endmodule

// File: tb/vid_ref_stepper_tb.sv
module vid_ref_stepper_tb;

    localparam int VW  = 5;
    localparam int RW  = 8;
    localparam int OFS = 16;
    localparam int SCL = 2;

    typedef struct {
        int    r;
        bit    b;
        string tr;
        string tb;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [VW-1:0] vid = '0;
    logic [RW-1:0] ref_code;
    logic          busy;

    int   total = 0;
    int   bad = 0;
    exp_t q[$];
    bit   seen = 1'b0;
    int   cur_ref = 0;
    int   last_r = 0;
    bit   last_b = 1'b0;

    always #2.5 clk = ~clk;

    vid_ref_stepper #(
        .VID_W(VW), .REF_W(RW), .REF_OFFSET(OFS), .REF_SCALE(SCL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(stb), .vid_code(vid),
        .ref_code(ref_code), .busy(busy)
    );

    function automatic int vmap(int v);
        return OFS + SCL * v;
    endfunction

    function automatic int toward(int s, int t, int n);
        int d;
        d = (t > s) ? t - s : s - t;
        if (n > d) n = d;
        return (t > s) ? s + n : s - n;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // monitor: pops one expected item per strobed edge
    always @(posedge clk) seen <= stb;

    always @(negedge clk) begin
        if (seen) begin
            if (q.size() == 0) begin
                check("R8 scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tr, int'(ref_code), e.r);
                check(e.tb, int'(busy), int'(e.b));
            end
        end
    end

    // driver
    task automatic strobe(int r, bit b, string tr, string tb);
        exp_t e;
        e.r = r; e.b = b; e.tr = tr; e.tb = tb;
        q.push_back(e);
        last_r = r; last_b = b;
        stb = 1'b1;
        @(posedge clk);
        #1;
        stb = 1'b0;
    endtask

    task automatic idle_gap();
        @(posedge clk);
        #1;
        check("R2 ref without strobe", int'(ref_code), last_r);
        check("R2 busy without strobe", int'(busy), int'(last_b));
    endtask

    task automatic do_reset(int v);
        rst_n = 1'b0;
        stb = 1'b0;
        vid = VW'(v);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cur_ref = vmap(v);
        check("R1 reset ref", int'(ref_code), cur_ref);
        check("R1 reset busy", int'(busy), 0);
        check("R10 map", int'(ref_code), OFS + SCL * v);
        last_r = cur_ref; last_b = 1'b0;
    endtask

    task automatic change_hold(int v, bit gap, string tag);
        int a, b, n, s;
        a = cur_ref; b = vmap(v);
        n = (b > a) ? b - a : a - b;
        s = 4 + 2 * n + 3;
        vid = VW'(v);
        for (int j = 1; j <= s; j++) begin
            int er;
            bit eb;
            er = toward(a, b, (j >= 4) ? (j - 4) / 2 : 0);
            eb = (j >= 2) && (j <= 4 + 2 * n);
            if (gap && j > 1) idle_gap();
            strobe(er, eb, (j < 6) ? "R4 hold before first step" : tag,
                   (j == 2) ? "R3 detect busy" : "R8 busy");
        end
        cur_ref = b;
    endtask

    task automatic glitch(int v, int hold);
        int old;
        old = int'(vid);
        vid = VW'(v);
        for (int j = 1; j <= hold + 5; j++) begin
            strobe(cur_ref, (j >= 2) && (j <= hold + 1), "R5 glitch ref", "R5 glitch busy");
            if (j == hold) vid = VW'(old);
        end
    endtask

    task automatic redirect(int vb, int vc, int k);
        int a, b, c, r, nc, s;
        a = cur_ref; b = vmap(vb); c = vmap(vc);
        r = toward(a, b, (k + 3 - 4) / 2);
        nc = (c > r) ? c - r : r - c;
        s = k + 4 + 2 * nc + 3;
        vid = VW'(vb);
        for (int j = 1; j <= s; j++) begin
            int er;
            if (j <= k + 3) er = toward(a, b, (j >= 4) ? (j - 4) / 2 : 0);
            else            er = toward(r, c, (j - (k + 4)) / 2);
            strobe(er, (j >= 2) && (j <= k + 4 + 2 * nc), "R9 redirect ref", "R9 redirect busy");
            if (j == k) vid = VW'(vc);
        end
        cur_ref = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        do_reset(5);                       // R1, R10: ref 26
        change_hold(9, 1'b0, "R6 step up");   // 26 -> 34
        change_hold(7, 1'b1, "R7 step down"); // 34 -> 30 with strobe gaps (R2)
        glitch(12, 1);                     // R5 one-strobe glitch
        glitch(3, 2);                      // R5 two-strobe glitch
        redirect(14, 2, 7);                // R9: 30 up toward 44, turn to 20
        check("R7 settled exactly", int'(ref_code), 20);
        check("R8 busy low settled", int'(busy), 0);
        do_reset(0);                       // R10 lowest code: 16
        change_hold(31, 1'b0, "R7 long up to 78");
        check("R7 top settled", int'(ref_code), 78);
        do_reset(31);                      // R10 highest code: 78
        repeat (3) @(negedge clk);
        check("R8 queue drained", q.size(), 0);
        summary();
        $finish;
    end

endmodule